// File: doc/BRIEF.md
# Synchronous Burst SRAM Datapath

This block is a single-port synchronous static memory with registered address, data and control inputs. Every rising clock edge captures one command. The address comes each cycle from an external burst sequencer, so the block itself never increments an address. A capture either writes the addressed word or reads it. Writes can cover any subset of the four byte lanes, or the whole word through a global write. A separate read-path mode input picks how the read data reaches the output. In flow-through mode the array's registered read is presented directly. In pipelined mode it passes through one more output register.

Selection follows the chip-select style of a commodity burst memory. Three enables are looked at only in cycles where the address strobe is high. Between strobes the last selection holds, so the continuing cycles of a burst need no enables. Deselect is handled more quickly than reads: once a deselect is captured, the output drive stops at once, even for read data that is still in flight. The output enable and the sleep input act on the drive enable without waiting for a clock. While sleep is high, captures are ignored and the memory keeps its contents.

Top module: `sync_burst_sram`

## Requirements
- R1: After synchronous reset, drive_en is low and the block is deselected: selected-style commands presented without a strobe read nothing and drive nothing.
- R2: A capture with adr_strobe high selects the block if en_a, en_b and en_c are all high, and deselects it if any of them is low. With adr_strobe low, the three enables are ignored and the previous selection holds.
- R3: A byte write (bw_en high, gw_en low) writes lane i, bits 8i+7..8i, for every byte_sel[i] that is high, and leaves the other lanes unchanged.
- R4: gw_en high writes all four lanes, whatever bw_en and byte_sel are.
- R5: A selected capture whose lane mask is empty (gw_en low, and either bw_en low or byte_sel zero) is a read.
- R6: With pipe_mode low (flow-through), the data of a read captured at edge e is on rdata with drive_en high after edge e+1, for one cycle.
- R7: With pipe_mode high (pipelined), the data of a read captured at edge e is on rdata with drive_en high after edge e+2, for one cycle.
- R8: A deselect captured at edge e holds drive_en low after edge e. Any earlier read whose data would be presented after that edge is dropped.
- R9: While oe is low, drive_en is low within the same cycle, without waiting for a clock edge.
- R10: While sleep is high, drive_en is low within the same cycle. Captures during sleep do not write, do not read, and do not change the selection, and the stored data is kept.
- R11: A read captured in the cycle right after a write to the same address returns the newly written data, in both read-path modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address from the burst sequencer |
| adr_strobe | input | 1 | Address strobe; the enables are sampled only when this is high |
| en_a | input | 1 | Chip enable A, active high |
| en_b | input | 1 | Chip enable B, active high |
| en_c | input | 1 | Chip enable C, active high |
| bw_en | input | 1 | Byte-write enable |
| byte_sel | input | NB | Per-lane write selects |
| gw_en | input | 1 | Global (all-lane) write |
| pipe_mode | input | 1 | 1 = pipelined read path, 0 = flow-through |
| oe | input | 1 | Output enable, acts without a clock |
| sleep | input | 1 | Low-power request; blocks captures and drive |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid while drive_en is high |
| drive_en | output | 1 | Enable for the external data bus driver |

## Verification
A wrong selection or a wrong read token in the capture or output stages shows up as drive_en being wrong. This appears one cycle after the capture in flow-through mode and two cycles after it in pipelined mode. A corrupted lane mask, or a read that goes to the wrong address, leaves the port data intact until that word is read back. The fault then shows on rdata in the presentation cycle of the read. Mistakes in the asynchronous gating of oe and sleep appear within the same cycle, before the next edge. For that reason the bench samples drive_en both just after it changes the inputs and at the falling edge.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  // One captured command as it moves down the read pipeline
  typedef struct packed {
    logic rd;     // selected read captured
    logic desel;  // strobe captured with an enable inactive
  } sbs_cmd_t;
endpackage

// File: rtl/sbs_capture.sv
module sbs_capture
  import sbs_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          adr_strobe,
  input  logic          en_a,
  input  logic          en_b,
  input  logic          en_c,
  input  logic          bw_en,
  input  logic [NB-1:0] byte_sel,
  input  logic          gw_en,
  input  logic          sleep,
  input  logic [DW-1:0] wdata,
  output sbs_cmd_t      cmd_q,
  output logic [NB-1:0] mask_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);
  logic          sel_q;
  logic          all_en, sel_nx, go;
  logic [NB-1:0] mask_c;

  always_comb begin
    all_en = en_a & en_b & en_c;
    sel_nx = adr_strobe ? all_en : sel_q;
    mask_c = gw_en ? {NB{1'b1}} : (bw_en ? byte_sel : {NB{1'b0}});
    go     = !sleep && sel_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q       <= 1'b0;
      cmd_q       <= '0;
      mask_q      <= '0;
    end else begin
      if (!sleep) sel_q <= sel_nx;
      cmd_q.rd    <= go && (mask_c == '0);
      cmd_q.desel <= !sleep && adr_strobe && !all_en;
      mask_q      <= go ? mask_c : '0;
    end
  end

  always_ff @(posedge clk) begin
    addr_q  <= addr;
    wdata_q <= wdata;
  end

  // R10: a capture under sleep neither reads nor writes, and selection holds
  a_r10_sleep_nop: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (!cmd_q.rd && mask_q == '0 && $stable(sel_q)));

  // R2: a strobe with any enable low yields a deselect, never an access
  a_r2_desel: assert property (@(posedge clk) disable iff (rst)
    (!sleep && adr_strobe && !(en_a && en_b && en_c))
      |=> (cmd_q.desel && !cmd_q.rd && mask_q == '0));

  // R4: a global write always carries a full lane mask or none
  a_r4_global: assert property (@(posedge clk) disable iff (rst)
    (!sleep && gw_en) |=> (!cmd_q.rd && (mask_q == '0 || &mask_q)));
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic [NB-1:0] wr_mask,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata_q
);
  localparam int LW    = DW / NB;
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_mask[g]) mem[addr] <= wdata[g*LW +: LW];
      rdata_q[g*LW +: LW] <= mem[addr];
    end
  end
endmodule

// File: rtl/sbs_outpath.sv
module sbs_outpath
  import sbs_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pipe_mode,
  input  logic          oe,
  input  logic          sleep,
  input  sbs_cmd_t      cmd_s1,
  input  logic [DW-1:0] arr_q,
  output logic [DW-1:0] rdata,
  output logic          drive_en
);
  sbs_cmd_t      cmd_s2;
  logic          rd_s3;
  logic [DW-1:0] pipe_q;
  logic          flow_ok, pipe_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_s2 <= '0;
      rd_s3  <= 1'b0;
    end else begin
      cmd_s2 <= cmd_s1;
      rd_s3  <= cmd_s2.rd;
    end
  end

  always_ff @(posedge clk) pipe_q <= arr_q;

  always_comb begin
    flow_ok  = cmd_s2.rd && !cmd_s1.desel;
    pipe_ok  = rd_s3 && !cmd_s2.desel && !cmd_s1.desel;
    drive_en = oe && !sleep && (pipe_mode ? pipe_ok : flow_ok);
    rdata    = pipe_mode ? pipe_q : arr_q;
  end

  // R6: flow-through drive only follows a read captured one edge earlier
  a_r6_flow_lat: assert property (@(posedge clk) disable iff (rst)
    (drive_en && !pipe_mode) |-> $past(cmd_s1.rd));

  // R7: pipelined drive only follows a read captured two edges earlier
  a_r7_pipe_lat: assert property (@(posedge clk) disable iff (rst)
    (drive_en && pipe_mode) |-> $past(cmd_s1.rd, 2));
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          adr_strobe,
  input  logic          en_a,
  input  logic          en_b,
  input  logic          en_c,
  input  logic          bw_en,
  input  logic [NB-1:0] byte_sel,
  input  logic          gw_en,
  input  logic          pipe_mode,
  input  logic          oe,
  input  logic          sleep,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          drive_en
);
  sbs_cmd_t      cmd_s1;
  logic [NB-1:0] mask_s1;
  logic [AW-1:0] addr_s1;
  logic [DW-1:0] wdata_s1;
  logic [DW-1:0] arr_q;

  sbs_capture #(.AW(AW), .DW(DW), .NB(NB)) u_capture (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .adr_strobe (adr_strobe),
    .en_a       (en_a),
    .en_b       (en_b),
    .en_c       (en_c),
    .bw_en      (bw_en),
    .byte_sel   (byte_sel),
    .gw_en      (gw_en),
    .sleep      (sleep),
    .wdata      (wdata),
    .cmd_q      (cmd_s1),
    .mask_q     (mask_s1),
    .addr_q     (addr_s1),
    .wdata_q    (wdata_s1)
  );

  sbs_array #(.AW(AW), .DW(DW), .NB(NB)) u_array (
    .clk     (clk),
    .wr_mask (mask_s1),
    .addr    (addr_s1),
    .wdata   (wdata_s1),
    .rdata_q (arr_q)
  );

  sbs_outpath #(.DW(DW)) u_outpath (
    .clk       (clk),
    .rst       (rst),
    .pipe_mode (pipe_mode),
    .oe        (oe),
    .sleep     (sleep),
    .cmd_s1    (cmd_s1),
    .arr_q     (arr_q),
    .rdata     (rdata),
    .drive_en  (drive_en)
  );
endmodule

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NB = 4;
  localparam int LW = DW / NB;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic [AW-1:0] ad = '0;
  logic          strobe = 1'b0, e1 = 1'b0, e2 = 1'b0, e3 = 1'b0;
  logic          bw = 1'b0, gw = 1'b0, pm = 1'b0, oe = 1'b0, slp = 1'b0;
  logic [NB-1:0] bs = '0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rdata;
  logic          drive_en;

  sync_burst_sram #(.AW(AW), .DW(DW), .NB(NB)) u_dut (
    .clk(clk), .rst(rst), .addr(ad), .adr_strobe(strobe),
    .en_a(e1), .en_b(e2), .en_c(e3), .bw_en(bw), .byte_sel(bs),
    .gw_en(gw), .pipe_mode(pm), .oe(oe), .sleep(slp), .wdata(wd),
    .rdata(rdata), .drive_en(drive_en)
  );

  int    tests = 0, fails = 0;
  string phase = "R1";
  bit    done = 0;

  // Behavioural reference: word store plus a history of the last three captures
  logic [DW-1:0] mref [2**AW];
  bit            h_rd [3];
  bit            h_ds [3];
  logic [DW-1:0] h_d  [3];
  bit            msel = 0;

  initial begin
    for (int i = 0; i < 3; i++) begin h_rd[i] = 0; h_ds[i] = 0; h_d[i] = '0; end
  end

  always @(posedge clk) begin : model
    bit            nrd, nds, sn, all;
    logic [DW-1:0] nd;
    logic [NB-1:0] mk;
    nrd = 0; nds = 0; nd = '0;
    if (rst) msel = 0;
    else if (!slp) begin
      all  = e1 && e2 && e3;
      sn   = strobe ? all : msel;
      msel = sn;
      nds  = strobe && !all;
      mk   = gw ? {NB{1'b1}} : (bw ? bs : {NB{1'b0}});
      if (sn) begin
        if (mk == '0) begin nrd = 1; nd = mref[ad]; end
        else for (int i = 0; i < NB; i++)
          if (mk[i]) mref[ad][i*LW +: LW] = wd[i*LW +: LW];
      end
    end
    for (int i = 2; i > 0; i--) begin
      h_rd[i] = h_rd[i-1]; h_ds[i] = h_ds[i-1]; h_d[i] = h_d[i-1];
    end
    h_rd[0] = nrd; h_ds[0] = nds; h_d[0] = nd;
  end

  task automatic check();
    bit            ed;
    logic [DW-1:0] edat;
    if (pm) begin ed = h_rd[2] && !h_ds[1] && !h_ds[0]; edat = h_d[2]; end
    else    begin ed = h_rd[1] && !h_ds[0];             edat = h_d[1]; end
    ed = ed && oe && !slp;
    tests++;
    if (drive_en !== ed) begin
      fails++;
      $display("FAIL %s drive_en actual %0b expected %0b at %0t", phase, drive_en, ed, $time);
    end else if (ed) begin
      tests++;
      if (rdata !== edat) begin
        fails++;
        $display("FAIL %s rdata actual %h expected %h at %0t", phase, rdata, edat, $time);
      end
    end
  endtask

  task automatic step();
    #1 check();
    @(negedge clk);
    check();
  endtask

  task automatic drv(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit s,
                     input logic [2:0] en, input bit b, input logic [NB-1:0] sel, input bit g);
    ad = a; wd = d; strobe = s; e1 = en[0]; e2 = en[1]; e3 = en[2];
    bw = b; bs = sel; gw = g;
    step();
  endtask

  task automatic rd(input logic [AW-1:0] a, input bit s);
    drv(a, '0, s, 3'b111, 1'b0, '0, 1'b0);
  endtask

  initial begin
    // R1: reset state, then unselected commands drive nothing
    phase = "R1";
    repeat (3) step();
    rst = 1'b0; oe = 1'b1; pm = 1'b0;
    rd(8'd0, 1'b0);
    rd(8'd1, 1'b0);
    rd(8'd2, 1'b0);

    // R4: global writes, some with byte controls that must not matter
    phase = "R4";
    for (int i = 0; i < 12; i++)
      drv(i[AW-1:0], 32'hA5000000 ^ (i * 32'h01030507), (i == 0), 3'b111,
          i[0], 4'b0101, 1'b1);

    // R3: byte-lane writes over previously known words
    phase = "R3";
    drv(8'd0, 32'hFFFFFFFF, 1'b0, 3'b000, 1'b1, 4'b0001, 1'b0);
    drv(8'd1, 32'h11223344, 1'b0, 3'b000, 1'b1, 4'b1010, 1'b0);
    drv(8'd2, 32'hDEADBEEF, 1'b0, 3'b000, 1'b1, 4'b0110, 1'b0);
    drv(8'd3, 32'hCAFEF00D, 1'b0, 3'b000, 1'b1, 4'b1111, 1'b0);

    // R5: empty lane mask reads instead of writing
    phase = "R5";
    drv(8'd4, 32'h0BADC0DE, 1'b0, 3'b111, 1'b1, 4'b0000, 1'b0);
    drv(8'd5, 32'h0BADC0DE, 1'b0, 3'b111, 1'b0, 4'b1111, 1'b0);
    rd(8'd4, 1'b0);

    // R6: flow-through burst; R2: enables ignored without strobe
    phase = "R6";
    for (int i = 0; i < 8; i++)
      drv(i[AW-1:0], '0, (i == 0), (i == 0) ? 3'b111 : 3'b000, 1'b0, '0, 1'b0);
    phase = "R2";
    drv(8'd6, '0, 1'b1, 3'b101, 1'b0, '0, 1'b0);
    rd(8'd7, 1'b0);
    rd(8'd8, 1'b0);
    drv(8'd9, '0, 1'b1, 3'b111, 1'b0, '0, 1'b0);
    rd(8'd10, 1'b0);

    // R7: pipelined burst
    phase = "R7";
    pm = 1'b1;
    for (int i = 0; i < 8; i++) rd(i[AW-1:0], 1'b0);
    rd(8'd11, 1'b0);

    // R11: write then immediate read of the same word, both modes
    phase = "R11";
    drv(8'd20, 32'h13572468, 1'b0, 3'b111, 1'b0, '0, 1'b1);
    rd(8'd20, 1'b0);
    rd(8'd1, 1'b0);
    pm = 1'b0;
    drv(8'd21, 32'h89ABCDEF, 1'b0, 3'b111, 1'b1, 4'b1100, 1'b0);
    rd(8'd21, 1'b0);
    rd(8'd2, 1'b0);

    // R8: deselect cuts drive at once, both modes
    phase = "R8";
    pm = 1'b1;
    rd(8'd0, 1'b0);
    rd(8'd1, 1'b0);
    drv(8'd2, '0, 1'b1, 3'b011, 1'b0, '0, 1'b0);
    rd(8'd3, 1'b0);
    rd(8'd4, 1'b0);
    rd(8'd5, 1'b1);
    rd(8'd6, 1'b0);
    pm = 1'b0;
    rd(8'd7, 1'b0);
    drv(8'd8, '0, 1'b1, 3'b110, 1'b0, '0, 1'b0);
    rd(8'd9, 1'b0);
    rd(8'd10, 1'b1);
    rd(8'd11, 1'b0);

    // R9: output enable removes drive within the cycle
    phase = "R9";
    for (int i = 0; i < 6; i++) begin
      oe = (i != 2 && i != 3);
      rd(i[AW-1:0], 1'b0);
    end
    oe = 1'b1;

    // R10: sleep blocks captures and drive, keeps data and selection
    phase = "R10";
    rd(8'd0, 1'b0);
    slp = 1'b1;
    drv(8'd0, 32'h55555555, 1'b0, 3'b111, 1'b0, '0, 1'b1);
    drv(8'd1, 32'h66666666, 1'b1, 3'b000, 1'b0, '0, 1'b1);
    rd(8'd2, 1'b0);
    slp = 1'b0;
    rd(8'd0, 1'b0);
    rd(8'd1, 1'b0);
    pm = 1'b1;
    rd(8'd2, 1'b0);
    rd(8'd3, 1'b0);
    rd(8'd3, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL %s watchdog expired", phase);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule